// File: doc/BRIEF.md
# Nested Priority Interrupt Arbiter

This block sits between up to eight interrupting devices and a processor. It keeps a running processor priority level, where 0 means ordinary code is executing and 1 through 8 mean a service routine of that rank is active. Each device has a fixed rank equal to its index plus one, so device 7 ranks highest. A device's request is taken only when its rank is strictly above the running level. When several eligible requests arrive together, the highest-ranked one wins.

On acceptance the arbiter raises the running level to the winner's rank. It pushes the old level onto an internal stack, pulses a one-hot acknowledge back to the winner, and presents an 8-bit vector naming the winner. A return strobe from the processor pops the stack, which restores the level that was active before the current service routine. That lets higher-ranked devices interrupt lower-ranked routines to any depth. A global enable input, which software drops at the start of a routine and raises at its end, gates every acceptance.

The vector output is a one-cycle pulse qualified by `vec_valid`. It has no ready input and takes no back-pressure: the processor must latch the code in the cycle it is valid. Requests are level-sensitive, and a device holds its request until it sees its acknowledge.

Top module: `prio_irq_arbiter`

## Requirements
- R1: A request from device i (rank i+1) is accepted only if i+1 is strictly greater than `cur_level`. A request at or below the level produces no acknowledge and no vector.
- R2: On acceptance `cur_level` becomes the rank of the accepted device. The previous level is pushed onto the level stack.
- R3: When several eligible requests are sampled in the same cycle, the one with the highest device index is accepted.
- R4: `vec_code` is {5-bit base 5'h15 in bits 7:3, accepted device index in bits 2:0}. It is valid in the cycle `vec_valid` is 1.
- R5: `ack` and `vec_valid` go high one clock after the winning request is sampled, for exactly one cycle. `ack` is one-hot on the winner's bit and is all zero whenever `vec_valid` is 0.
- R6: While `glob_en` is 0, no request is accepted.
- R7: A cycle with `rti` high sets `cur_level` to the most recently pushed level and removes it from the stack. No request is accepted in a cycle with `rti` high.
- R8: `rti` with an empty stack leaves `cur_level` at 0 and sets `stk_fault`. A push onto a full stack also sets it. `stk_fault` stays set until reset.
- R9: After reset `cur_level` is 0, `ack` is 0, `vec_valid` is 0 and `stk_fault` is 0.
- R10: A device that keeps its request asserted after being acknowledged is not accepted again while `cur_level` is at or above its rank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 8 | Level-sensitive request, one bit per device; bit i has rank i+1 |
| glob_en | input | 1 | Global acceptance enable |
| rti | input | 1 | Return-from-service strobe; restores the previous level |
| ack | output | 8 | One-cycle one-hot acknowledge to the accepted device |
| vec_valid | output | 1 | Vector code valid, one-cycle pulse |
| vec_code | output | 8 | Vector: base in bits 7:3, device index in bits 2:0 |
| cur_level | output | 4 | Running processor priority level, 0 to 8 |
| stk_fault | output | 1 | Sticky level-stack overflow/underflow flag |

## Verification
Every result of this block is registered once. A request or return strobe sampled at one rising edge shows its acknowledge, vector, new level and fault flag immediately after that edge. The bench therefore changes inputs on the falling edge and compares outputs on the next falling edge, half a period after the edge that produced them. Each table row holds its stimulus for exactly one cycle, so every comparison sees the effect of that row and no other. The fault tests sample the flag both in the cycle right after the faulting strobe and one idle cycle later, to show that it is sticky.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  parameter int unsigned DEF_DEVS      = 8;
  parameter int unsigned DEF_STK_DEPTH = 8;
  parameter int unsigned DEF_BASE_W    = 5;
  parameter logic [4:0]  DEF_VEC_BASE  = 5'h15;

  typedef enum logic [1:0] {
    LV_HOLD   = 2'd0,
    LV_RAISE  = 2'd1,
    LV_RETURN = 2'd2
  } lvl_op_e;
endpackage

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int unsigned DEVS  = 8,
  parameter int unsigned LVL_W = 4,
  parameter int unsigned IDX_W = 3
) (
  input  logic [DEVS-1:0]  req,
  input  logic [LVL_W-1:0] level,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  logic [DEVS-1:0] elig;

  // A device is eligible only when its rank (index + 1) beats the running level.
  generate
    for (genvar g = 0; g < DEVS; g++) begin : g_elig
      assign elig[g] = req[g] && (LVL_W'(g + 1) > level);
    end
  endgenerate

  // Ascending scan: a later (higher-index) hit overrides an earlier one.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < DEVS; i++) begin
      if (elig[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/prio_stack.sv
module prio_stack #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [LVL_W-1:0] din,
  output logic [LVL_W-1:0] top,
  output logic             empty,
  output logic             fault
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [LVL_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic             full;

  assign empty = (cnt == '0);
  assign full  = (cnt == CNT_W'(DEPTH));
  assign top   = empty ? '0 : mem[cnt - 1'b1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      fault <= 1'b0;
    end else if (push) begin
      if (full) fault <= 1'b1;
      else begin
        mem[cnt] <= din;
        cnt      <= cnt + 1'b1;
      end
    end else if (pop) begin
      if (empty) fault <= 1'b1;
      else       cnt   <= cnt - 1'b1;
    end
  end

  p_fault_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);
  p_underflow_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && empty) |=> fault);
  p_no_push_with_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));
endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter
  import prio_irq_pkg::*;
#(
  parameter int unsigned DEVS      = DEF_DEVS,
  parameter int unsigned STK_DEPTH = DEF_STK_DEPTH,
  parameter int unsigned BASE_W    = DEF_BASE_W,
  parameter logic [BASE_W-1:0] VEC_BASE = DEF_VEC_BASE,
  localparam int unsigned IDX_W = (DEVS > 1) ? $clog2(DEVS) : 1,
  localparam int unsigned LVL_W = $clog2(DEVS + 1),
  localparam int unsigned VEC_W = BASE_W + IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEVS-1:0]  irq_req,
  input  logic             glob_en,
  input  logic             rti,
  output logic [DEVS-1:0]  ack,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vec_code,
  output logic [LVL_W-1:0] cur_level,
  output logic             stk_fault
);
  logic             found;
  logic [IDX_W-1:0] win_idx;
  logic             accept;
  logic [LVL_W-1:0] stk_top;
  logic             stk_empty;
  lvl_op_e          op;

  prio_pick #(.DEVS(DEVS), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_pick (
    .req   (irq_req),
    .level (cur_level),
    .found (found),
    .idx   (win_idx)
  );

  // A return strobe takes the cycle: no acceptance alongside a pop.
  assign accept = glob_en && !rti && found;

  always_comb begin
    if (accept)   op = LV_RAISE;
    else if (rti) op = LV_RETURN;
    else          op = LV_HOLD;
  end

  prio_stack #(.DEPTH(STK_DEPTH), .LVL_W(LVL_W)) u_stack (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (op == LV_RAISE),
    .pop   (op == LV_RETURN),
    .din   (cur_level),
    .top   (stk_top),
    .empty (stk_empty),
    .fault (stk_fault)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_level <= '0;
      ack       <= '0;
      vec_valid <= 1'b0;
      vec_code  <= '0;
    end else begin
      ack       <= '0;
      vec_valid <= 1'b0;
      unique case (op)
        LV_RAISE: begin
          cur_level    <= LVL_W'(win_idx) + 1'b1;
          ack[win_idx] <= 1'b1;
          vec_valid    <= 1'b1;
          vec_code     <= {VEC_BASE, win_idx};
        end
        LV_RETURN: cur_level <= stk_empty ? '0 : stk_top;
        default: ;
      endcase
    end
  end

  p_raise_outranks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> cur_level > $past(cur_level));
  p_level_is_rank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> cur_level == LVL_W'(vec_code[IDX_W-1:0]) + 1'b1);
  p_vec_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> vec_code[VEC_W-1:IDX_W] == VEC_BASE);
  p_ack_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $countones(ack) == 1);
  p_ack_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid |-> ack == '0);
  p_disabled_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |=> !vec_valid);
  p_return_no_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rti |=> !vec_valid && cur_level <= $past(cur_level));
endmodule

// File: tb/prio_irq_arbiter_test.sv
module prio_irq_arbiter_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] irq_req;
  logic       glob_en;
  logic       rti;
  logic [7:0] ack;
  logic       vec_valid;
  logic [7:0] vec_code;
  logic [3:0] cur_level;
  logic       stk_fault;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  prio_irq_arbiter uut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .glob_en(glob_en), .rti(rti),
    .ack(ack), .vec_valid(vec_valid), .vec_code(vec_code),
    .cur_level(cur_level), .stk_fault(stk_fault)
  );

  // Row layout: {glob_en, rti, irq_req[8], exp_ack[8], exp_valid, exp_level[4]}
  localparam int NROWS = 13;
  localparam logic [22:0] ROWS [NROWS] = '{
    {1'b1, 1'b0, 8'h01, 8'h01, 1'b1, 4'd1},  // R1 R2: dev0 over level 0
    {1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 4'd1},  // idle
    {1'b1, 1'b0, 8'h01, 8'h00, 1'b0, 4'd1},  // R10: rank equal to level, refused
    {1'b1, 1'b0, 8'h24, 8'h20, 1'b1, 4'd6},  // R3: dev5 beats dev2
    {1'b1, 1'b0, 8'h04, 8'h00, 1'b0, 4'd6},  // R1: rank 3 below level 6
    {1'b0, 1'b0, 8'h80, 8'h00, 1'b0, 4'd6},  // R6: disabled
    {1'b1, 1'b0, 8'h80, 8'h80, 1'b1, 4'd8},  // R2: nest to level 8
    {1'b1, 1'b0, 8'h80, 8'h00, 1'b0, 4'd8},  // R10: held request not retaken
    {1'b1, 1'b1, 8'h00, 8'h00, 1'b0, 4'd6},  // R7: pop to 6
    {1'b1, 1'b1, 8'h40, 8'h00, 1'b0, 4'd1},  // R7: pop to 1, request blocked
    {1'b1, 1'b0, 8'h40, 8'h40, 1'b1, 4'd7},  // R4: dev6 vector
    {1'b1, 1'b1, 8'h00, 8'h00, 1'b0, 4'd1},  // R7
    {1'b1, 1'b1, 8'h00, 8'h00, 1'b0, 4'd0}   // R7: back to level 0
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_vec(input logic [7:0] onehot);
    logic [2:0] ix = '0;
    for (int b = 0; b < 8; b++) if (onehot[b]) ix = 3'(b);
    return {5'h15, ix};
  endfunction

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq_req = '0; glob_en = 1'b0; rti = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 level", 32'(cur_level), 32'd0);
    chk("R9 ack", 32'(ack), 32'd0);
    chk("R9 valid", 32'(vec_valid), 32'd0);
    chk("R9 fault", 32'(stk_fault), 32'd0);

    for (int r = 0; r < NROWS; r++) begin
      glob_en = ROWS[r][22];
      rti     = ROWS[r][21];
      irq_req = ROWS[r][20:13];
      @(negedge clk);
      chk("R5 ack", 32'(ack), 32'(ROWS[r][12:5]));
      chk("R5 valid", 32'(vec_valid), 32'(ROWS[r][4]));
      chk("R2 level", 32'(cur_level), 32'(ROWS[r][3:0]));
      if (ROWS[r][4]) chk("R4 vector", 32'(vec_code), 32'(exp_vec(ROWS[r][12:5])));
    end

    // R8: return with empty stack
    irq_req = '0; rti = 1'b0;
    @(negedge clk);
    chk("R8 fault clear before", 32'(stk_fault), 32'd0);
    rti = 1'b1;
    @(negedge clk);
    rti = 1'b0;
    chk("R8 level stays 0", 32'(cur_level), 32'd0);
    chk("R8 fault set", 32'(stk_fault), 32'd1);
    @(negedge clk);
    chk("R8 fault sticky", 32'(stk_fault), 32'd1);

    // R3: three-way tie, highest index wins
    irq_req = 8'h1A;
    @(negedge clk);
    irq_req = '0;
    chk("R3 ack", 32'(ack), 32'h10);
    chk("R3 level", 32'(cur_level), 32'd5);
    chk("R4 vector", 32'(vec_code), 32'hAC);
    @(negedge clk);
    chk("R5 pulse ends", 32'(vec_valid), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule